// File: doc/BRIEF.md
# Paged Outbound Address Translator

This block sits between a narrow local memory-mapped slave port and the request side of a wide serial link. It turns each local address into a 64-bit link address. The local address is split into two parts. The low part is the offset within a page and passes straight through. The part just above it is a page number that indexes a small table. The selected table entry supplies the upper link address bits. Its two lowest bits are an attribute that says whether the outgoing access uses 32-bit or 64-bit link addressing.

Software fills the table through a separate register port, one 64-bit entry per 8-byte slot. The page size and the number of pages are parameters. A page size that falls in the unsupported window is rejected when the design is elaborated.

A parameter-selected bypass variant has no paging. In that variant a local address of configurable width is zero-extended onto the link address, and the table is not consulted. Requests pass through a single registered stage with ready/valid flow control on both sides.

Top module: `ob_page_xlate`

## Requirements
- R1: With page size 2^PAGE_BITS, link address bits [PAGE_BITS-1:0] equal local address bits [PAGE_BITS-1:0].
- R2: The local port is PAGE_BITS+log2(NUM_PAGES) bits wide. Local bits [PAGE_BITS+log2(NUM_PAGES)-1:PAGE_BITS] select the table entry. With 16 pages of 64 KB, bits [19:16] pick one of 16 entries on a 20-bit port.
- R3: An entry whose bits [1:0] are 2'b01 selects 64-bit addressing. Link bits [63:PAGE_BITS] come from entry bits [63:PAGE_BITS], and out_is64_o is 1.
- R4: An entry whose bits [1:0] are any other value (2'b00, 2'b10, 2'b11) selects 32-bit addressing. Link bits [63:32] are zero, link bits [31:PAGE_BITS] come from the entry, and out_is64_o is 0.
- R5: Entry k is written when cfg_we_i is high and cfg_addr_i[log2(NUM_PAGES)+2:3] equals k, with cfg_addr_i[2:0] ignored. cfg_rdata_o returns the whole 64-bit entry addressed by cfg_addr_i in the same cycle.
- R6: If a table write and an accepted lookup of the same entry happen in the same cycle, the lookup uses the old entry value. The next request uses the new value.
- R7: A request accepted at a clock edge appears on out_valid_o, out_addr_o and out_is64_o right after that edge. This is one cycle of latency.
- R8: in_ready_o is high when the output stage is empty or out_ready_i is high. While out_valid_o is high and out_ready_i is low, the outputs hold steady.
- R9: After reset every table entry is zero (32-bit addressing, zero upper address), and out_valid_o is low.
- R10: With BYPASS=1, out_addr_o is the BYPASS_AW-bit local address zero-extended to 64 bits, and out_is64_o is 1, whatever the table holds.
- R11: The page-size check accepts PAGE_BITS from 12 to 16 and from 22 to 31, and rejects 17 to 21. An unsupported value in paged mode stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Local request valid |
| in_ready_o | output | 1 | Local request accepted when high with valid |
| in_addr_i | input | IN_AW | Local byte address |
| out_valid_o | output | 1 | Translated request valid |
| out_ready_i | input | 1 | Downstream can take the translated request |
| out_addr_o | output | 64 | Translated link address |
| out_is64_o | output | 1 | 1 means 64-bit link addressing, 0 means 32-bit |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | log2(NUM_PAGES)+3 | Table byte address, entry index times 8 |
| cfg_wdata_i | input | 64 | Table write data |
| cfg_rdata_o | output | 64 | Table read data for cfg_addr_i |

## Verification
The vector walk sends addresses with different page numbers and offsets. It covers entries holding each of the four attribute codes, an entry left at its reset value, and the top page with an all-ones offset. Together these separate the offset passthrough, the index decode, and the 32-bit against 64-bit upper-bit handling. A write and a lookup of the same entry in the same cycle show whether the lookup sees the old or the new value. A stall with a second request waiting checks the hold and the handoff of the output stage. A bypass instance whose table is filled with ones shows that the table has no effect on the link address there.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned ENTRY_W = 64;
  localparam logic [1:0] ATTR_64 = 2'b01;

  typedef logic [ENTRY_W-1:0] entry_t;

  // 17..21 cannot be split between table and offset
  function automatic bit page_bits_ok(int unsigned p);
    return (p >= 12) && (p <= 31) && !((p >= 17) && (p <= 21));
  endfunction
endpackage

// File: rtl/xlate_table.sv
module xlate_table
  import xlate_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_PAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  entry_t           wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output entry_t           rdata_o,
  input  logic [IDX_W-1:0] lidx_i,
  output entry_t           lentry_o
);
  entry_t mem_q [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        mem_q[g] <= '0;
      else if (we_i && (widx_i == IDX_W'(g)))             mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o  = mem_q[ridx_i];
  assign lentry_o = mem_q[lidx_i];
endmodule

// File: rtl/xlate_map.sv
module xlate_map
  import xlate_pkg::*;
#(
  parameter int unsigned IN_AW     = 20,
  parameter int unsigned PAGE_BITS = 16,
  parameter bit          BYPASS    = 1'b0
) (
  input  logic [IN_AW-1:0] in_addr_i,
  input  entry_t           entry_i,
  output logic [63:0]      addr_o,
  output logic             is64_o
);
  if (BYPASS) begin : g_bypass
    entry_t unused_entry;
    assign unused_entry = entry_i;
    assign addr_o = 64'(in_addr_i);
    assign is64_o = 1'b1;
  end else begin : g_paged
    logic unused_low;
    assign unused_low = ^entry_i[PAGE_BITS-1:2];
    always_comb begin
      is64_o = (entry_i[1:0] == ATTR_64);
      if (is64_o) addr_o = {entry_i[63:PAGE_BITS], in_addr_i[PAGE_BITS-1:0]};
      else        addr_o = {32'b0, entry_i[31:PAGE_BITS], in_addr_i[PAGE_BITS-1:0]};
    end
  end
endmodule

// File: rtl/ob_page_xlate.sv
module ob_page_xlate
  import xlate_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 16,
  parameter int unsigned NUM_PAGES = 16,
  parameter bit          BYPASS    = 1'b0,
  parameter int unsigned BYPASS_AW = 22,
  parameter int unsigned IN_AW     = BYPASS ? BYPASS_AW : PAGE_BITS + $clog2(NUM_PAGES),
  parameter int unsigned CFG_AW    = $clog2(NUM_PAGES) + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [IN_AW-1:0]  in_addr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [63:0]       out_addr_o,
  output logic              out_is64_o,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [63:0]       cfg_wdata_i,
  output logic [63:0]       cfg_rdata_o
);
  localparam int unsigned IDX_W = $clog2(NUM_PAGES);

  if (!BYPASS && !page_bits_ok(PAGE_BITS)) begin : g_bad_page
    $error("ob_page_xlate: PAGE_BITS %0d not supported", PAGE_BITS);
  end

  logic [IDX_W-1:0] lidx;
  entry_t           lentry;
  logic [63:0]      map_addr;
  logic             map_is64;
  logic             accept;
  logic             unused_cfg_lo;

  assign unused_cfg_lo = ^cfg_addr_i[2:0];

  if (BYPASS) begin : g_idx_bp
    assign lidx = '0;
  end else begin : g_idx_pg
    assign lidx = in_addr_i[PAGE_BITS +: IDX_W];
  end

  xlate_table #(.NUM_PAGES(NUM_PAGES)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .widx_i   (cfg_addr_i[CFG_AW-1:3]),
    .wdata_i  (cfg_wdata_i),
    .ridx_i   (cfg_addr_i[CFG_AW-1:3]),
    .rdata_o  (cfg_rdata_o),
    .lidx_i   (lidx),
    .lentry_o (lentry)
  );

  xlate_map #(.IN_AW(IN_AW), .PAGE_BITS(PAGE_BITS), .BYPASS(BYPASS)) u_map (
    .in_addr_i (in_addr_i),
    .entry_i   (lentry),
    .addr_o    (map_addr),
    .is64_o    (map_is64)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_addr_o  <= '0;
      out_is64_o  <= 1'b0;
    end else if (accept) begin
      out_valid_o <= 1'b1;
      out_addr_o  <= map_addr;
      out_is64_o  <= map_is64;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ob_page_xlate_chk.sv
module ob_page_xlate_chk #(
  parameter int unsigned IN_AW     = 20,
  parameter int unsigned PAGE_BITS = 16,
  parameter bit          BYPASS    = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [IN_AW-1:0] in_addr_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [63:0]      out_addr_o,
  input logic             out_is64_o
);
  a_r7_valid_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_addr_o) && $stable(out_is64_o)));

  a_r8_empty_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_is64_o) |-> (out_addr_o[63:32] == 32'b0));

  if (BYPASS) begin : g_bp
    a_r10_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && in_ready_o) |=> (out_is64_o && (out_addr_o == 64'($past(in_addr_i)))));
  end else begin : g_pg
    a_r1_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && in_ready_o) |=> (out_addr_o[PAGE_BITS-1:0] == $past(in_addr_i[PAGE_BITS-1:0])));
  end
endmodule

bind ob_page_xlate ob_page_xlate_chk #(
  .IN_AW(IN_AW), .PAGE_BITS(PAGE_BITS), .BYPASS(BYPASS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_addr_i   (in_addr_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_addr_o  (out_addr_o),
  .out_is64_o  (out_is64_o)
);

// File: tb/ob_page_xlate_tb.sv
module ob_page_xlate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam int NE = 5;

  // table contents programmed before the vector walk
  localparam logic [3:0]  ENT_IDX [NE] = '{4'd3, 4'd5, 4'd15, 4'd7, 4'd9};
  localparam logic [63:0] ENT_VAL [NE] = '{
    64'h1234_5678_9ABC_0001, 64'hFFFF_FFFF_DEAD_0000, 64'h0000_0001_0000_0001,
    64'hAAAA_0000_5555_0002, 64'h8000_0000_0000_0003};

  localparam logic [19:0] V_IN  [NV] = '{20'h0_1234, 20'h3_ABCD, 20'h5_0010,
                                         20'hF_FFFF, 20'h7_0000, 20'h9_00FF};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h0000_0000_0000_1234, 64'h1234_5678_9ABC_ABCD, 64'h0000_0000_DEAD_0010,
    64'h0000_0001_0000_FFFF, 64'h0000_0000_5555_0000, 64'h0000_0000_0000_00FF};
  localparam logic        V_64  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        in_valid = 1'b0, out_ready = 1'b1, cfg_we = 1'b0;
  logic [19:0] in_addr = '0;
  logic [6:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        in_ready, out_valid, out_is64;
  logic [63:0] out_addr, cfg_rdata;

  logic        bp_in_valid = 1'b0, bp_cfg_we = 1'b0;
  logic [21:0] bp_in_addr = '0;
  logic [6:0]  bp_cfg_addr = '0;
  logic [63:0] bp_cfg_wdata = '0;
  logic        bp_in_ready, bp_out_valid, bp_out_is64;
  logic [63:0] bp_out_addr, bp_cfg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ob_page_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_addr_i(in_addr), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_addr_o(out_addr), .out_is64_o(out_is64), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata));

  ob_page_xlate #(.BYPASS(1'b1), .BYPASS_AW(22)) u_dut_bp (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(bp_in_valid), .in_ready_o(bp_in_ready),
    .in_addr_i(bp_in_addr), .out_valid_o(bp_out_valid), .out_ready_i(1'b1),
    .out_addr_o(bp_out_addr), .out_is64_o(bp_out_is64), .cfg_we_i(bp_cfg_we),
    .cfg_addr_i(bp_cfg_addr), .cfg_wdata_i(bp_cfg_wdata), .cfg_rdata_o(bp_cfg_rdata));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [3:0] idx, logic [63:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {idx, 3'b000}; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one request; outputs are checked one negedge later
  task automatic send(logic [19:0] a, logic [63:0] exp, logic e64, string req);
    @(negedge clk);
    chk("R7 idle before accept", 64'(out_valid), 64'd0);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 valid after one cycle", 64'(out_valid), 64'd1);
    chk(req, out_addr, exp);
    chk({req, " size flag"}, 64'(out_is64), 64'(e64));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    #1;
    chk("R9 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R8 ready when empty", 64'(in_ready), 64'd1);
    cfg_addr = {4'd3, 3'b000}; #1;
    chk("R9 entry zero after reset", cfg_rdata, 64'd0);

    // R11 page-size acceptance
    chk("R11 16 ok", 64'(xlate_pkg::page_bits_ok(16)), 64'd1);
    chk("R11 17 rejected", 64'(xlate_pkg::page_bits_ok(17)), 64'd0);
    chk("R11 21 rejected", 64'(xlate_pkg::page_bits_ok(21)), 64'd0);
    chk("R11 22 ok", 64'(xlate_pkg::page_bits_ok(22)), 64'd1);

    for (int i = 0; i < NE; i++) cfg_wr(ENT_IDX[i], ENT_VAL[i]);

    // R5 readback, low address bits ignored
    @(negedge clk);
    cfg_addr = {4'd7, 3'b101}; #1;
    chk("R5 readback entry 7", cfg_rdata, ENT_VAL[3]);
    cfg_addr = {4'd15, 3'b010}; #1;
    chk("R5 readback entry 15", cfg_rdata, ENT_VAL[2]);

    // R1 R2 R3 R4 vector walk
    for (int i = 0; i < NV; i++) send(V_IN[i], V_EXP[i], V_64[i], "R1 R2 R3 R4 vector");

    // R6 same-cycle write and lookup of entry 4
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {4'd4, 3'b000}; cfg_wdata = 64'h0000_0002_0000_0001;
    in_valid = 1'b1; in_addr = 20'h4_0042;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R6 lookup sees old entry", out_addr, 64'h0000_0000_0000_0042);
    chk("R6 old size flag", 64'(out_is64), 64'd0);
    send(20'h4_0042, 64'h0000_0002_0000_0042, 1'b1, "R6 next request sees new entry");

    // R8 backpressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 20'h3_0001;
    @(negedge clk);
    in_addr = 20'h5_0002;
    chk("R8 ready low when stalled", 64'(in_ready), 64'd0);
    chk("R7 first stalled output", out_addr, 64'h1234_5678_9ABC_0001);
    @(negedge clk);
    chk("R8 output held", out_addr, 64'h1234_5678_9ABC_0001);
    chk("R8 valid held", 64'(out_valid), 64'd1);
    out_ready = 1'b1; #1;
    chk("R8 ready follows out_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 waiting request handed over", out_addr, 64'h0000_0000_DEAD_0002);
    chk("R8 handed over size flag", 64'(out_is64), 64'd0);

    // R10 bypass ignores table
    @(negedge clk);
    bp_cfg_we = 1'b1; bp_cfg_addr = '0; bp_cfg_wdata = '1;
    @(negedge clk);
    bp_cfg_we = 1'b0;
    bp_in_valid = 1'b1; bp_in_addr = 22'h3F_FFFF;
    @(negedge clk);
    bp_in_addr = 22'h00_0005;
    chk("R10 bypass all ones", bp_out_addr, 64'h0000_0000_003F_FFFF);
    chk("R10 bypass size flag", 64'(bp_out_is64), 64'd1);
    @(negedge clk);
    bp_in_valid = 1'b0;
    chk("R10 bypass small", bp_out_addr, 64'h0000_0000_0000_0005);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule